// File: doc/BRIEF.md
# Memory Refresh Slot Scheduler

This block tracks which access slot of a scan line the video memory port is in, and marks the slots that belong to memory refresh. A DMA engine or an external requester uses the refresh flag to stay off the memory port in those slots.

Two horizontal resolutions are supported. The wide mode has 40 cells and the narrow mode has 32 cells. The mode input is sampled only when a new line begins, so a mode change in the middle of a line does not move the refresh positions or the wrap point of that line.

While a DMA runs whose target is anything other than a video RAM write, the block reserves a second set of slots. Each of these extra slots sits three slots before one of the regular refresh slots. The slot index updates on the clock edge that sees a strobe. The refresh flag is decoded combinationally from the registered slot, the latched mode and the live DMA inputs.

Top module: `refresh_slot_sched`

## Requirements
- R1: After reset the slot index is 0, the latched mode is narrow and the refresh flag is 0.
- R2: A line-start strobe sets the slot index to 0 on the next edge and latches the mode input (1 = wide, 0 = narrow). If a slot-advance strobe arrives in the same cycle, line start wins.
- R3: A slot-advance strobe without line start raises the index by one. From the last slot of the line it returns to 0. The wide line has 214 slots (0 to 213) and the narrow line has 171 slots (0 to 170). With neither strobe present, the index holds its value.
- R4: A change of the mode input between two line starts has no effect on the refresh flag or on the wrap point of the current line.
- R5: In wide mode the flag is 1 at slots 37, 69, 102, 133, 165 and 197, and at every slot from 210 upward, whatever the DMA inputs are.
- R6: In wide mode, while DMA runs with a non-VRAM-write target, the flag is also 1 at slots 34, 66, 99, 130, 162 and 194.
- R7: In narrow mode the flag is 1 at slots 24, 56, 88, 120 and 152, whatever the DMA inputs are.
- R8: In narrow mode, while DMA runs with a non-VRAM-write target, the flag is also 1 at slots 21, 53, 85, 117 and 149.
- R9: The target is read from bits 3:0 of the DMA code, and the value 4'b0001 means a VRAM write. No extra slot is added when DMA-run is low, or when bits 3:0 equal 4'b0001; bits above 3 have no effect. Every slot not listed in R5 to R8 has a flag of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode_i | input | 1 | Mode request, 1 = 40-cell, sampled at line start |
| line_start_i | input | 1 | Start-of-line strobe |
| slot_adv_i | input | 1 | Advance to next slot |
| dma_run_i | input | 1 | A DMA transfer is in progress |
| dma_code_i | input | 6 | DMA access code, bits 3:0 select the target |
| slot_o | output | 8 | Current slot index within the line |
| refresh_o | output | 1 | Current slot is reserved for refresh |

## Verification
The assertions assume that slot-advance strobes arrive only after a line start has set up the line, and that the strobe inputs are clean 0/1 values at every clock edge. The range check on the slot index also depends on the index never starting out past the end of the latched line. Reset and the line-start rule ensure this, and no strobe can skip the wrap.

The stimulus drives all inputs on the falling edge, so they are stable at each rising edge. Every line begins with a line-start pulse. The bench keeps its own copy of the slot and the latched mode, so the mode input can be toggled mid-line without ever putting the design in a state the assertions do not cover.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

  typedef enum logic {
    HMODE_NARROW = 1'b0,
    HMODE_WIDE   = 1'b1
  } hmode_e;

  // Slots owned by refresh regardless of DMA activity.
  function automatic logic fixed_refresh(hmode_e mode, int unsigned s, int unsigned tail_from);
    if (mode == HMODE_WIDE)
      return (s inside {37, 69, 102, 133, 165, 197}) || (s >= tail_from);
    else
      return s inside {24, 56, 88, 120, 152};
  endfunction

  // Extra slots taken while a non-VRAM-write DMA is running.
  function automatic logic dma_stolen(hmode_e mode, int unsigned s);
    if (mode == HMODE_WIDE)
      return s inside {34, 66, 99, 130, 162, 194};
    else
      return s inside {21, 53, 85, 117, 149};
  endfunction

  // Number of slots in one line for a given mode.
  function automatic int unsigned line_slots(hmode_e mode, int unsigned wide_n, int unsigned narrow_n);
    return (mode == HMODE_WIDE) ? wide_n : narrow_n;
  endfunction

endpackage

// File: rtl/rs_mode_latch.sv
module rs_mode_latch
  import refresh_sched_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   line_start,
  input  hmode_e mode_req,
  output hmode_e mode_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)          mode_q <= HMODE_NARROW;
    else if (line_start) mode_q <= mode_req;
  end

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(mode_q));

  // R2
  mode_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> mode_q == $past(mode_req));

endmodule

// File: rtl/rs_slot_counter.sv
module rs_slot_counter
  import refresh_sched_pkg::*;
#(
  parameter int unsigned WIDE_SLOTS   = 214,
  parameter int unsigned NARROW_SLOTS = 171,
  parameter int unsigned SLOT_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              slot_adv,
  input  hmode_e            mode,
  output logic [SLOT_W-1:0] slot
);

  localparam logic [SLOT_W-1:0] WIDE_LAST   = SLOT_W'(WIDE_SLOTS - 1);
  localparam logic [SLOT_W-1:0] NARROW_LAST = SLOT_W'(NARROW_SLOTS - 1);

  logic [SLOT_W-1:0] last_slot;
  logic              at_last;
  logic              step_evt;
  logic              wrap_evt;

  assign last_slot = (mode == HMODE_WIDE) ? WIDE_LAST : NARROW_LAST;
  assign at_last   = (slot == last_slot);
  assign step_evt  = slot_adv && !line_start && !at_last;
  assign wrap_evt  = slot_adv && !line_start && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n)                     slot <= '0;
    else if (line_start || wrap_evt) slot <= '0;
    else if (step_evt)              slot <= slot + 1'b1;
  end

  // R3
  slot_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= last_slot);

  // R2
  line_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> slot == '0);

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> slot == $past(slot) + 1'b1);

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> slot == '0);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_adv && !line_start) |=> $stable(slot));

endmodule

// File: rtl/rs_refresh_decode.sv
module rs_refresh_decode
  import refresh_sched_pkg::*;
#(
  parameter int unsigned SLOT_W       = 8,
  parameter int unsigned CODE_W       = 6,
  parameter int unsigned TGT_W        = 4,
  parameter logic [3:0]  VRAM_WR_CODE = 4'b0001,
  parameter int unsigned TAIL_FROM    = 210
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hmode_e            mode,
  input  logic [SLOT_W-1:0] slot,
  input  logic              dma_run,
  input  logic [CODE_W-1:0] dma_code,
  output logic              refresh
);

  logic [TGT_W-1:0] target;
  logic             steal_ok;
  logic             base_hit;
  logic             steal_hit;

  assign target    = dma_code[TGT_W-1:0];
  assign steal_ok  = dma_run && (target != TGT_W'(VRAM_WR_CODE));
  assign base_hit  = fixed_refresh(mode, int'(slot), TAIL_FROM);
  assign steal_hit = dma_stolen(mode, int'(slot));
  assign refresh   = base_hit || (steal_ok && steal_hit);

  generate
    if (CODE_W > TGT_W) begin : g_hi
      logic unused_code_hi;
      assign unused_code_hi = ^dma_code[CODE_W-1:TGT_W];
    end
  endgenerate

  // R5 R7
  base_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_hit |-> refresh);

  // R9
  no_steal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !steal_ok |-> (refresh == base_hit));

  // R6 R8
  steal_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (steal_ok && steal_hit) |-> refresh);

endmodule

// File: rtl/refresh_slot_sched.sv
module refresh_slot_sched
  import refresh_sched_pkg::*;
#(
  parameter int unsigned WIDE_SLOTS   = 214,
  parameter int unsigned NARROW_SLOTS = 171,
  parameter int unsigned TAIL_FROM    = 210,
  parameter int unsigned CODE_W       = 6,
  parameter int unsigned TGT_W        = 4,
  parameter logic [3:0]  VRAM_WR_CODE = 4'b0001,
  localparam int unsigned SLOT_W      = $clog2(WIDE_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode_i,
  input  logic              line_start_i,
  input  logic              slot_adv_i,
  input  logic              dma_run_i,
  input  logic [CODE_W-1:0] dma_code_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              refresh_o
);

  hmode_e mode_q;

  rs_mode_latch u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start_i),
    .mode_req   (hmode_e'(wide_mode_i)),
    .mode_q     (mode_q)
  );

  rs_slot_counter #(
    .WIDE_SLOTS   (WIDE_SLOTS),
    .NARROW_SLOTS (NARROW_SLOTS),
    .SLOT_W       (SLOT_W)
  ) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start_i),
    .slot_adv   (slot_adv_i),
    .mode       (mode_q),
    .slot       (slot_o)
  );

  rs_refresh_decode #(
    .SLOT_W       (SLOT_W),
    .CODE_W       (CODE_W),
    .TGT_W        (TGT_W),
    .VRAM_WR_CODE (VRAM_WR_CODE),
    .TAIL_FROM    (TAIL_FROM)
  ) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .slot     (slot_o),
    .dma_run  (dma_run_i),
    .dma_code (dma_code_i),
    .refresh  (refresh_o)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (slot_o == '0 && mode_q == HMODE_NARROW));

endmodule

// File: tb/test_refresh_slot_sched.sv
`timescale 1ns/1ps
module test_refresh_slot_sched;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wide_mode_i = 1'b0;
  logic       line_start_i = 1'b0;
  logic       slot_adv_i = 1'b0;
  logic       dma_run_i = 1'b0;
  logic [5:0] dma_code_i = '0;
  logic [7:0] slot_o;
  logic       refresh_o;

  always #4 clk = ~clk;

  refresh_slot_sched i_refresh_slot_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .wide_mode_i  (wide_mode_i),
    .line_start_i (line_start_i),
    .slot_adv_i   (slot_adv_i),
    .dma_run_i    (dma_run_i),
    .dma_code_i   (dma_code_i),
    .slot_o       (slot_o),
    .refresh_o    (refresh_o)
  );

  typedef struct {
    int slot;
    bit refr;
    int req;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   m_slot = 0;
  bit   m_wide = 1'b0;

  int wide_ref[6]   = '{37, 69, 102, 133, 165, 197};
  int narrow_ref[5] = '{24, 56, 88, 120, 152};

  function automatic int line_len(bit wide);
    return wide ? 214 : 171;
  endfunction

  // Model: extra DMA slots lie three before each listed fixed slot (R6 R8 R9)
  function automatic bit model_ref(bit wide, int s, bit run, logic [5:0] code);
    bit hit = 1'b0;
    bit dma_extra = run && (code[3:0] != 4'b0001);
    if (wide) begin
      if (s >= 210) hit = 1'b1;
      foreach (wide_ref[k]) begin
        if (s == wide_ref[k]) hit = 1'b1;
        if (dma_extra && s == wide_ref[k] - 3) hit = 1'b1;
      end
    end else begin
      foreach (narrow_ref[k]) begin
        if (s == narrow_ref[k]) hit = 1'b1;
        if (dma_extra && s == narrow_ref[k] - 3) hit = 1'b1;
      end
    end
    return hit;
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected outcome
  task automatic drive(bit ls, bit adv, bit mode, bit run, logic [5:0] code, int req);
    exp_t e;
    @(negedge clk);
    line_start_i = ls;
    slot_adv_i   = adv;
    wide_mode_i  = mode;
    dma_run_i    = run;
    dma_code_i   = code;
    if (ls) begin
      m_slot = 0;
      m_wide = mode;
    end else if (adv) begin
      m_slot = (m_slot == line_len(m_wide) - 1) ? 0 : m_slot + 1;
    end
    e.slot = m_slot;
    e.refr = model_ref(m_wide, m_slot, run, code);
    e.req  = req;
    exp_q.push_back(e);
  endtask

  // Full line: start, every slot, then one extra advance that must wrap (R3)
  task automatic sweep(bit wide, bit run, logic [5:0] code, int req, int flip_at);
    drive(1'b1, 1'b0, wide, run, code, req);
    for (int n = 1; n < line_len(wide); n++)
      drive(1'b0, 1'b1, (n >= flip_at) ? !wide : wide, run, code, req);
    drive(1'b0, 1'b1, (flip_at < 1000) ? !wide : wide, run, code, 3);
  endtask

  // Monitor: compares after each rising edge has settled
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++;
      if (slot_o !== 8'(e.slot) || refresh_o !== e.refr) begin
        n_bad++;
        $display("FAIL R%0d: slot=%0d refresh=%0b expected slot=%0d refresh=%0b",
                 e.req, slot_o, refresh_o, e.slot, e.refr);
      end
    end
  end

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    dma_run_i  = 1'b1;
    dma_code_i = 6'h03;
    @(negedge clk);
    // R1: reset state
    n_cmp++;
    if (slot_o !== 8'd0 || refresh_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: slot=%0d refresh=%0b expected slot=0 refresh=0", slot_o, refresh_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
    dma_run_i = 1'b0;

    // R7: narrow, no DMA
    sweep(1'b0, 1'b0, 6'h03, 7, 1000);
    // R8: narrow, DMA to non-VRAM target
    sweep(1'b0, 1'b1, 6'h03, 8, 1000);
    // R9: narrow, VRAM write code with upper bit set adds nothing
    sweep(1'b0, 1'b1, 6'h21, 9, 1000);
    // R5: wide, no DMA
    sweep(1'b1, 1'b0, 6'h05, 5, 1000);
    // R6: wide, DMA to non-VRAM target
    sweep(1'b1, 1'b1, 6'h05, 6, 1000);
    // R9: wide, non-VRAM code but DMA idle
    sweep(1'b1, 1'b0, 6'h0C, 9, 1000);
    // R4: wide line with the mode input dropping mid-line
    sweep(1'b1, 1'b1, 6'h02, 4, 40);
    // R4: narrow line with the mode input rising mid-line
    sweep(1'b0, 1'b1, 6'h02, 4, 10);

    // R3: hold with no strobe
    drive(1'b1, 1'b0, 1'b0, 1'b0, 6'h00, 2);
    repeat (5) drive(1'b0, 1'b1, 1'b0, 1'b0, 6'h00, 3);
    repeat (4) drive(1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 3);
    // R2: line start beats a same-cycle advance
    drive(1'b1, 1'b1, 1'b1, 1'b0, 6'h00, 2);
    repeat (37) drive(1'b0, 1'b1, 1'b0, 1'b0, 6'h00, 5);

    @(posedge clk);
    #4;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule